// File: doc/BRIEF.md
# Chain Conversion Readback Sequencer

This block runs one complete convert-and-read pass across a daisy chain of battery monitor devices, each of which yields 12 result channels: six cell-voltage channels and six auxiliary channels. A one-cycle `start` latches the chain length, the acquisition-time code and the averaging code. The block then sends two broadcast command frames. The first points every device at the first cell result. The second starts a conversion on chip-select with the chosen averaging. All frames leave through a valid/ready command stream, and each carries an 8-bit CRC built by an internal codec.

After the second command is accepted, the block waits for the conversion to finish. The wait is derived in hardware from the acquisition time, the averaging count and the chain length, and is counted in microsecond ticks made from a clock-frequency parameter. The block then issues one read transfer per result frame. Each returning frame is taken from a valid/ready response stream and its CRC is checked. A good frame is forwarded unchanged on a valid/ready result stream.

While forwarding, the block adds the 12-bit value of every cell-voltage frame to a running sum. It pulses `done` when the pass ends. A bad CRC ends the pass at once and raises `err`.

Stream rules:
- The command stream holds `cmd_valid` and `cmd_frame` until `cmd_ready` is seen.
- The result stream holds `res_valid` and `res_data` until `res_ready` is seen, and no further read transfer is issued before that.
- `rsp_ready` is high only while a response is awaited, so a response offered at any other time is not taken.

Top module: `chain_readback_seq`

## Requirements
- R1: The first frame of a pass has device field [31:27]=0, register field [26:21]=0x1C, data [20:13]=0x00, broadcast bit [12]=1, bit [11]=0, CRC in [10:3] and [2:0]=3'b010. The CRC is the remainder of bits [31:11] divided by x^8+x^5+x^3+x^2+x+1.
- R2: The second frame has the same layout, with register 0x0D and data 0x08 | (avg_code<<1), broadcast bit set.
- R3: The first read transfer starts ceil(T/1000)+5 microsecond ticks after the second frame is accepted. T = (tA+695)·12·A − tA + (N−1)·250 ns. tA is 465, 1010, 1460 or 1890 for acquisition codes 0 to 3. A is 1, 2, 4 or 8 for averaging codes 0 to 3. N is the device count.
- R4: A pass issues exactly 12·N read transfers, each the frame with device field 0x1F and all other fields 0 plus CRC. N is `chain_len` clamped to the range 1 to 8.
- R5: A response frame is good when bits [9:2] equal the CRC remainder of bits [31:10]. Each good frame appears unchanged on `res_data` with `res_valid` one cycle after it is accepted.
- R6: `cell_sum` is the sum of field [22:11] over the good frames whose channel field [26:23] is 5 or less. Frames on channels 6 to 11 are forwarded but not summed.
- R7: A response with a bad CRC is not forwarded. It ends the pass with `done` and `err` high in the next cycle, and no further transfers follow.
- R8: `done` is high for exactly one cycle per pass. `cell_sum` and `err` hold their values until the next accepted start, which clears both.
- R9: A start pulse that arrives while a pass is busy is ignored, together with its configuration inputs.
- R10: `cmd_valid` and `cmd_frame`, and likewise `res_valid` and `res_data`, stay stable until their ready is seen. `rsp_ready` is low outside the wait for a response.
- R11: After reset no stream is valid, `rsp_ready`, `done` and `err` are low, and `cell_sum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass when idle |
| chain_len | input | 4 | Number of devices (clamped 1..8) |
| acq_code | input | 2 | Acquisition-time code |
| avg_code | input | 2 | Averaging code |
| cmd_valid | output | 1 | Command/read frame valid |
| cmd_ready | input | 1 | Command sink ready |
| cmd_frame | output | 32 | Outgoing frame |
| rsp_valid | input | 1 | Response frame valid |
| rsp_ready | output | 1 | Response accepted this cycle |
| rsp_frame | input | 32 | Incoming response frame |
| res_valid | output | 1 | Result frame valid |
| res_ready | input | 1 | Result sink ready |
| res_data | output | 32 | Forwarded good frame |
| cell_sum | output | 32 | Sum of cell-voltage results |
| done | output | 1 | One-cycle end-of-pass pulse |
| err | output | 1 | Pass ended on CRC error |

## Verification
The end-of-pass `done` pulse and a new `start` can fall in the same cycle. In that cycle the block is already idle, so the start must be taken. The bench provokes this by raising `start` in exactly the cycle where it observes `done`. It then judges that `cell_sum` reads 0 one cycle later and that a full second pass follows, with the correct first frame. Busy-time starts are provoked during the read phase, and are judged by the exact frame count and the sum of the pass in flight.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CADDR, S_CCTRL, S_WAIT, S_RDREQ, S_RDRSP, S_RES
  } seq_state_t;

  localparam logic [5:0] REG_RDADDR = 6'h1C;
  localparam logic [5:0] REG_CTLHI  = 6'h0D;
  localparam logic [4:0] DEV_MASTER = 5'h00;
  localparam logic [4:0] DEV_TOP    = 5'h1F;
  localparam logic [7:0] CRC_POLY   = 8'h2F;

  function automatic logic [10:0] acq_ns(input logic [1:0] code);
    case (code)
      2'd0:    acq_ns = 11'd465;
      2'd1:    acq_ns = 11'd1010;
      2'd2:    acq_ns = 11'd1460;
      default: acq_ns = 11'd1890;
    endcase
  endfunction
endpackage

// File: rtl/chseq_crc8.sv
module chseq_crc8 #(
  parameter int W = 21,
  parameter logic [7:0] POLY = 8'h2F
) (
  input  logic [W-1:0] din,
  output logic [7:0]   rem
);
  always_comb begin
    logic [7:0] r;
    logic fb;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      fb = r[7];
      r  = {r[6:0], din[i]} ^ (fb ? POLY : 8'h00);
    end
    rem = r;
  end
endmodule

// File: rtl/chseq_wait_timer.sv
module chseq_wait_timer #(
  parameter int CLK_MHZ = 125,
  parameter int DEV_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [1:0]       acq_code,
  input  logic [1:0]       avg_code,
  input  logic [DEV_W-1:0] ndev,
  output logic             expired
);
  import chseq_pkg::*;
  localparam int NS_W  = 20;
  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

  logic [NS_W-1:0]  t_ns, mult, conv_ns, target, acc;
  logic [PRE_W-1:0] pre;

  always_comb begin
    t_ns    = NS_W'(acq_ns(acq_code));
    mult    = NS_W'(12) << avg_code;
    conv_ns = (t_ns + NS_W'(695)) * mult - t_ns + (NS_W'(ndev) - NS_W'(1)) * NS_W'(250);
    target  = conv_ns + NS_W'(5000);
  end

  assign expired = (acc >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      acc <= '0;
    end else if (arm) begin
      pre <= '0;
      acc <= '0;
    end else if (pre == PRE_W'(CLK_MHZ - 1)) begin
      pre <= '0;
      if (!expired) acc <= acc + NS_W'(1000);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  // R3
  acc_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> acc >= $past(acc));
endmodule

// File: rtl/chain_readback_seq.sv
module chain_readback_seq #(
  parameter int CLK_MHZ       = 125,
  parameter int MAX_DEV       = 8,
  parameter int CH_PER_DEV    = 12,
  parameter int CELLS_PER_DEV = 6,
  parameter int SUM_W         = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  chain_len,
  input  logic [1:0]  acq_code,
  input  logic [1:0]  avg_code,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_frame,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_frame,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_data,
  output logic [SUM_W-1:0] cell_sum,
  output logic        done,
  output logic        err
);
  import chseq_pkg::*;
  localparam int DEV_W = 4;
  localparam int CNT_W = $clog2(MAX_DEV * CH_PER_DEV + 1);

  seq_state_t       st;
  logic [DEV_W-1:0] ndev_q, ndev_in;
  logic [1:0]       acq_q, avg_q;
  logic [CNT_W-1:0] rd_cnt, total;
  logic [20:0]      tx_hdr;
  logic [7:0]       tx_crc, rx_crc;
  logic             arm, expired, crc_ok, is_cell, last_frame, take_start;

  always_comb begin
    if (chain_len == '0) ndev_in = DEV_W'(1);
    else if (chain_len > DEV_W'(MAX_DEV)) ndev_in = DEV_W'(MAX_DEV);
    else ndev_in = chain_len;
  end

  always_comb begin
    case (st)
      S_CADDR: tx_hdr = {DEV_MASTER, REG_RDADDR, 8'h00, 1'b1, 1'b0};
      S_CCTRL: tx_hdr = {DEV_MASTER, REG_CTLHI, {4'b0000, 1'b1, avg_q, 1'b0}, 1'b1, 1'b0};
      default: tx_hdr = {DEV_TOP, 6'h00, 8'h00, 1'b0, 1'b0};
    endcase
  end

  chseq_crc8 #(.W(21), .POLY(CRC_POLY)) u_tx_crc (.din(tx_hdr), .rem(tx_crc));
  chseq_crc8 #(.W(22), .POLY(CRC_POLY)) u_rx_crc (.din(rsp_frame[31:10]), .rem(rx_crc));

  chseq_wait_timer #(.CLK_MHZ(CLK_MHZ), .DEV_W(DEV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .acq_code(acq_q),
    .avg_code(avg_q), .ndev(ndev_q), .expired(expired)
  );

  assign cmd_frame  = {tx_hdr, tx_crc, 3'b010};
  assign cmd_valid  = (st == S_CADDR) || (st == S_CCTRL) || (st == S_RDREQ);
  assign rsp_ready  = (st == S_RDRSP);
  assign arm        = (st == S_CCTRL) && cmd_ready;
  assign crc_ok     = (rx_crc == rsp_frame[9:2]);
  assign is_cell    = (rsp_frame[26:23] < 4'(CELLS_PER_DEV));
  assign total      = CNT_W'(ndev_q) * CNT_W'(CH_PER_DEV);
  assign last_frame = (rd_cnt == total - CNT_W'(1));
  assign take_start = (st == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ndev_q <= DEV_W'(1); acq_q <= '0; avg_q <= '0;
      rd_cnt <= '0; res_valid <= 1'b0; res_data <= '0;
      cell_sum <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ndev_q <= ndev_in; acq_q <= acq_code; avg_q <= avg_code;
          rd_cnt <= '0; cell_sum <= '0; err <= 1'b0; st <= S_CADDR;
        end
        S_CADDR: if (cmd_ready) st <= S_CCTRL;
        S_CCTRL: if (cmd_ready) st <= S_WAIT;
        S_WAIT:  if (expired) st <= S_RDREQ;
        S_RDREQ: if (cmd_ready) st <= S_RDRSP;
        S_RDRSP: if (rsp_valid) begin
          if (crc_ok) begin
            res_valid <= 1'b1;
            res_data  <= rsp_frame;
            if (is_cell) cell_sum <= cell_sum + SUM_W'(rsp_frame[22:11]);
            st <= S_RES;
          end else begin
            err <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end
        end
        S_RES: if (res_ready) begin
          res_valid <= 1'b0;
          if (last_frame) begin
            done <= 1'b1; st <= S_IDLE;
          end else begin
            rd_cnt <= rd_cnt + CNT_W'(1); st <= S_RDREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_frame));
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  // R5
  res_from_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(rsp_valid && rsp_ready));
  // R6
  sum_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_ready) && !take_start |=> $stable(cell_sum));
endmodule

// File: tb/chain_readback_seq_bench.sv
module chain_readback_seq_bench;
  localparam int M = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cmd_ready = 0, rsp_valid = 0, res_ready = 0;
  logic [3:0] chain_len = 4'd1;
  logic [1:0] acq_code = 0, avg_code = 0;
  logic [31:0] rsp_frame = 0;
  logic cmd_valid, rsp_ready, res_valid, done, err;
  logic [31:0] cmd_frame, res_data, cell_sum;
  int checks = 0, fails = 0, cyc = 0;

  chain_readback_seq #(.CLK_MHZ(M)) u_chain_readback_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_len(chain_len),
    .acq_code(acq_code), .avg_code(avg_code), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_frame(cmd_frame), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_frame(rsp_frame), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .cell_sum(cell_sum),
    .done(done), .err(err));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // fields: [27:24] len [23:22] acq [21:20] avg [19] stall [18] poke [17:10] bad [9:0] seed
  localparam logic [27:0] VEC [6] = '{
    {4'd1,  2'd0, 2'd0, 1'b0, 1'b0, 8'hFF, 10'd1},
    {4'd2,  2'd1, 2'd1, 1'b1, 1'b0, 8'hFF, 10'd7},
    {4'd0,  2'd3, 2'd2, 1'b0, 1'b1, 8'hFF, 10'd3},
    {4'd12, 2'd2, 2'd3, 1'b0, 1'b0, 8'hFF, 10'd9},
    {4'd3,  2'd0, 2'd0, 1'b1, 1'b0, 8'd17,  10'd5},
    {4'd1,  2'd2, 2'd0, 1'b0, 1'b0, 8'd11,  10'd2}
  };

  function automatic logic [7:0] crc_rem(input logic [31:0] v, input int w);
    logic [7:0] r = 0;
    for (int i = w - 1; i >= 0; i--) begin
      logic fb = r[7];
      r = {r[6:0], v[i]} ^ (fb ? 8'h2F : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [4:0] dv, input logic [5:0] rg,
                                         input logic [7:0] dt, input logic all);
    logic [20:0] h = {dv, rg, dt, all, 1'b0};
    return {h, crc_rem({11'd0, h}, 21), 3'b010};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cmd();
    while (!cmd_valid) @(negedge clk);
  endtask

  task automatic accept(input bit stall);
    logic [31:0] f = cmd_frame;
    if (stall) repeat (2) begin
      @(negedge clk);
      check(cmd_valid && cmd_frame == f, "R10 cmd hold", cmd_frame, f);
    end
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
  endtask

  task automatic run_pass(input logic [3:0] len, input logic [1:0] acq, input logic [1:0] avg,
                          input bit stall, input bit poke, input int bad, input int seed,
                          input bit skip_start, input bit chain_next);
    int nd, tq, ns, k, h, d;
    logic [31:0] sum = 0, fr;
    nd = (len == 0) ? 1 : ((len > 8) ? 8 : int'(len));
    tq = (acq == 0) ? 465 : (acq == 1) ? 1010 : (acq == 2) ? 1460 : 1890;
    ns = (tq + 695) * 12 * (1 << avg) - tq + (nd - 1) * 250;
    k  = (ns + 999) / 1000 + 5;
    if (!skip_start) begin
      start = 1; chain_len = len; acq_code = acq; avg_code = avg;
      @(negedge clk); start = 0;
    end
    wait_cmd();
    check(cmd_frame == mk_cmd(5'h00, 6'h1C, 8'h00, 1'b1), "R1 first frame", cmd_frame, mk_cmd(5'h00, 6'h1C, 8'h00, 1'b1));
    check(!rsp_ready, "R10 rsp_ready idle", {31'd0, rsp_ready}, 0);
    accept(stall);
    wait_cmd();
    check(cmd_frame == mk_cmd(5'h00, 6'h0D, {4'b0, 1'b1, avg, 1'b0}, 1'b1), "R2 control frame",
          cmd_frame, mk_cmd(5'h00, 6'h0D, {4'b0, 1'b1, avg, 1'b0}, 1'b1));
    accept(1'b0);
    h = cyc;
    wait_cmd();
    d = cyc - h;
    check(d >= k * M && d <= k * M + 2, "R3 wait cycles", d, k * M + 1);
    for (int i = 0; i < 12 * nd; i++) begin
      wait_cmd();
      check(cmd_frame == mk_cmd(5'h1F, 6'h00, 8'h00, 1'b0), "R4 read frame", cmd_frame, mk_cmd(5'h1F, 6'h00, 8'h00, 1'b0));
      if (i == 0 && poke) begin
        start = 1; chain_len = 4'd5; @(negedge clk); start = 0; chain_len = len;  // R9
      end
      accept(1'b0);
      while (!rsp_ready) @(negedge clk);
      begin
        logic [21:0] top = {5'(i / 12), 4'(i % 12), 12'((seed * 37 + i * 113) & 12'hFFF), 1'b0};
        fr = {top, crc_rem({10'd0, top}, 22), 2'b00};
      end
      if (i == bad) fr = fr ^ 32'h4;
      rsp_valid = 1; rsp_frame = fr; @(negedge clk); rsp_valid = 0;
      if (i == bad) begin
        check(done && err && !res_valid, "R7 crc abort", {29'd0, done, err, res_valid}, 32'h6);
        repeat (3) begin
          @(negedge clk);
          check(!cmd_valid && err && !done && cell_sum == sum, "R7 R8 held after abort", cell_sum, sum);
        end
        return;
      end
      check(res_valid && res_data == fr, "R5 forwarded frame", res_data, fr);
      if (i % 12 < 6) sum = sum + 32'(fr[22:11]);  // R6 cells only
      if (stall) repeat (2) begin
        @(negedge clk);
        check(res_valid && res_data == fr, "R10 res hold", res_data, fr);
      end
      res_ready = 1; @(negedge clk); res_ready = 0;
      if (i == 12 * nd - 1) begin
        check(done && !err, "R8 done pulse", {30'd0, done, err}, 32'h2);
        check(cell_sum == sum, "R6 cell sum", cell_sum, sum);
        if (chain_next) begin
          start = 1; @(negedge clk); start = 0;
          check(cell_sum == 0 && !done, "R8 sum cleared on start", cell_sum, 0);
          return;
        end
        @(negedge clk);
        check(!done && cell_sum == sum, "R8 done one cycle, sum held", cell_sum, sum);
        repeat (3) @(negedge clk);
        check(!cmd_valid && cell_sum == sum, "R4 R9 no extra frames", {31'd0, cmd_valid}, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cmd_valid && !res_valid && !rsp_ready && !done && !err && cell_sum == 0, "R11 reset state",
          {27'd0, cmd_valid, res_valid, rsp_ready, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!cmd_valid && cell_sum == 0, "R11 after release", cell_sum, 0);
    for (int v = 0; v < 6; v++)
      run_pass(VEC[v][27:24], VEC[v][23:22], VEC[v][21:20], VEC[v][19], VEC[v][18],
               (VEC[v][17:10] == 8'hFF) ? -1 : int'(VEC[v][17:10]), int'(VEC[v][9:0]), 1'b0, 1'b0);
    // start in the same cycle as done
    chain_len = 4'd1; acq_code = 2'd1; avg_code = 2'd0;
    run_pass(4'd1, 2'd1, 2'd0, 1'b0, 1'b0, -1, 11, 1'b0, 1'b1);
    run_pass(4'd1, 2'd1, 2'd0, 1'b1, 1'b0, -1, 13, 1'b1, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule